// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block watches a group of asynchronous input lines and raises a match when a configurable sum-of-products expression over them becomes true. The expression is built from a row of bit slices. Each slice picks one synchronised input, then tests it against one of eight conditions: constant true, constant false, high or low level, an edge that is remembered, or an edge that lasts only one cycle.

Adjacent slices are ANDed together into a product term. A term closes at a slice whose endpoint flag is set, and the last slice always closes a term. The registered result of each term is reported on the status bit of its closing slice. The OR of all terms is the overall match. An optional one-cycle event marks each rise of that match.

A one-cycle reset-detect command forgets every remembered edge. It also captures a vector that reads 1 for every slice that had not matched. A mode input keeps the engine idle while the surrounding logic uses the lines for plain pin interrupts.

Top module: `pattern_match_engine`

## Requirements
- R1: Slice k takes its input index from bits [3k+2:3k] of `cfg_src_i` and observes that input after a two-flop synchroniser.
- R2: Slice k takes its condition from bits [3k+2:3k] of `cfg_cond_i`, encoded as: 0 always true, 1 remembered rise, 2 remembered fall, 3 remembered rise or fall, 4 input high, 5 input low, 6 always false, 7 rise or fall in the current cycle only.
- R3: A remembered-edge condition (codes 1 to 3) becomes true in the cycle its edge is seen on the synchronised input. It stays true until a reset-detect command; a clear and a new edge in the same cycle leave it cleared.
- R4: Code 7 is true only in the single cycle in which an edge is seen on the synchronised input.
- R5: A product term is the AND of the conditions from the slice after the previous endpoint up to and including the endpoint slice. The endpoint flag of slice k is bit k of `cfg_endp_i`, and the last slice is always an endpoint.
- R6: Status bit k is the registered result of the term closing at slice k. A bit for a slice that is not an endpoint reads 0. An input change sampled at clock edge n reaches the status after edge n+2.
- R7: `match_o` is the OR of the status bits. `event_o` is high for exactly one cycle, together with each 0-to-1 rise of `match_o`, and only if `evt_en_i` was high at the edge that raised the match.
- R8: While `pm_mode_i` is low, the status, match and event outputs are 0 and all remembered edges are cleared.
- R9: On a clock edge where `detect_clr_i` is high, `clr_status_o` loads the inverse of the status held before that edge. It then holds that value until the next command.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_IN | Asynchronous input lines |
| cfg_src_i | input | NUM_SLICE*SEL_W | Input select per slice |
| cfg_cond_i | input | NUM_SLICE*3 | Condition code per slice |
| cfg_endp_i | input | NUM_SLICE | Endpoint flag per slice |
| pm_mode_i | input | 1 | 1 = pattern-match operation, 0 = idle |
| evt_en_i | input | 1 | Enables the event pulse |
| detect_clr_i | input | 1 | Reset-detect command, one cycle |
| match_status_o | output | NUM_SLICE | Registered product-term results |
| match_o | output | 1 | OR of all product terms |
| event_o | output | 1 | One-cycle pulse on each match rise |
| clr_status_o | output | NUM_SLICE | Captured not-matched vector from the last command |

## Verification
The assertions check the following on every cycle:
- The event pulse never lasts two cycles and only follows an enabled edge.
- Status bits appear only on endpoint slices.
- The outputs stay zero while the mode is off.
- The captured vector is the inverse of the prior status.
- A remembered edge is always gone after a clear.

Some behaviours need the bench's reference model and its scenarios:
- Product-term grouping under different endpoint layouts.
- The forced endpoint on the last slice.
- Remembered edges persisting after the line returns.
- The single-cycle life of the non-remembered edge.
- Exactly one event per match rise.

// File: rtl/pm_pkg.sv
package pm_pkg;

   typedef enum logic [2:0] {
      PM_TRUE      = 3'd0,
      PM_STK_RISE  = 3'd1,
      PM_STK_FALL  = 3'd2,
      PM_STK_ANY   = 3'd3,
      PM_HIGH      = 3'd4,
      PM_LOW       = 3'd5,
      PM_FALSE     = 3'd6,
      PM_EDGE_NOW  = 3'd7
   } pm_cond_e;

   localparam int unsigned PM_COND_W = 3;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] lvl_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pm_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign lvl_o  = stg_q[STAGES-1];
   assign rise_o = stg_q[STAGES-1] & ~prev_q;
   assign fall_o = ~stg_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pm_slice.sv
module pm_slice
   import pm_pkg::*;
#(
   parameter int unsigned NUM_IN = 8,
   localparam int unsigned SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] lvl_i,
   input  logic [NUM_IN-1:0] rise_i,
   input  logic [NUM_IN-1:0] fall_i,
   input  logic [SEL_W-1:0]  src_i,
   input  logic [PM_COND_W-1:0] cond_i,
   input  logic              run_i,
   input  logic              clr_i,
   output logic              cond_o
);

   logic     sel_lvl, sel_rise, sel_fall;
   logic     edge_hit;
   logic     sticky_q;
   pm_cond_e code;

   assign code = pm_cond_e'(cond_i);

   if (NUM_IN == (1 << SEL_W)) begin : g_full_sel
      assign sel_lvl  = lvl_i[src_i];
      assign sel_rise = rise_i[src_i];
      assign sel_fall = fall_i[src_i];
   end else begin : g_part_sel
      logic in_range;
      assign in_range = (int'(src_i) < NUM_IN);
      assign sel_lvl  = in_range & lvl_i[src_i];
      assign sel_rise = in_range & rise_i[src_i];
      assign sel_fall = in_range & fall_i[src_i];
   end

   always_comb begin
      unique case (code)
         PM_STK_RISE: edge_hit = sel_rise;
         PM_STK_FALL: edge_hit = sel_fall;
         PM_STK_ANY:  edge_hit = sel_rise | sel_fall;
         default:     edge_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sticky_q <= 1'b0;
      else if (clr_i || !run_i)  sticky_q <= 1'b0;
      else if (edge_hit)         sticky_q <= 1'b1;
   end

   always_comb begin
      unique case (code)
         PM_TRUE:     cond_o = 1'b1;
         PM_STK_RISE,
         PM_STK_FALL,
         PM_STK_ANY:  cond_o = sticky_q | edge_hit;
         PM_HIGH:     cond_o = sel_lvl;
         PM_LOW:      cond_o = ~sel_lvl;
         PM_FALSE:    cond_o = 1'b0;
         PM_EDGE_NOW: cond_o = sel_rise | sel_fall;
         default:     cond_o = 1'b0;
      endcase
   end

   // R3: a reset-detect command always leaves the remembered edge cleared
   assert_sticky_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !sticky_q);

   // R8: idle mode leaves no remembered edge behind
   assert_sticky_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !sticky_q);

endmodule

// File: rtl/pm_chain.sv
module pm_chain #(
   parameter int unsigned NUM_SLICE = 8
) (
   input  logic [NUM_SLICE-1:0] cond_i,
   input  logic [NUM_SLICE-1:0] endp_i,
   output logic [NUM_SLICE-1:0] eff_endp_o,
   output logic [NUM_SLICE-1:0] term_o
);

   always_comb begin
      eff_endp_o = endp_i;
      eff_endp_o[NUM_SLICE-1] = 1'b1;
   end

   always_comb begin
      logic run;
      run    = 1'b1;
      term_o = '0;
      for (int k = 0; k < NUM_SLICE; k++) begin
         run       = run & cond_i[k];
         term_o[k] = run & eff_endp_o[k];
         if (eff_endp_o[k]) run = 1'b1;
      end
   end

endmodule

// File: rtl/pattern_match_engine.sv
module pattern_match_engine
   import pm_pkg::*;
#(
   parameter int unsigned NUM_IN      = 8,
   parameter int unsigned NUM_SLICE   = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_IN-1:0]              pins_i,
   input  logic [NUM_SLICE*SEL_W-1:0]     cfg_src_i,
   input  logic [NUM_SLICE*PM_COND_W-1:0] cfg_cond_i,
   input  logic [NUM_SLICE-1:0]           cfg_endp_i,
   input  logic                           pm_mode_i,
   input  logic                           evt_en_i,
   input  logic                           detect_clr_i,
   output logic [NUM_SLICE-1:0]           match_status_o,
   output logic                           match_o,
   output logic                           event_o,
   output logic [NUM_SLICE-1:0]           clr_status_o
);

   if (NUM_SLICE < 1 || NUM_SLICE > 64) begin : g_bad_slices
      $error("pattern_match_engine: NUM_SLICE out of range");
   end
   if (NUM_IN < 1 || NUM_IN > 64) begin : g_bad_inputs
      $error("pattern_match_engine: NUM_IN out of range");
   end

   logic [NUM_IN-1:0]    lvl, rise, fall;
   logic [NUM_SLICE-1:0] cond_vec, term_vec, eff_endp;
   logic [NUM_SLICE-1:0] status_q, clr_q, status_d;
   logic                 event_q;

   pm_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(pins_i),
      .lvl_o  (lvl),
      .rise_o (rise),
      .fall_o (fall)
   );

   for (genvar k = 0; k < NUM_SLICE; k++) begin : g_slice
      pm_slice #(.NUM_IN(NUM_IN)) u_slice (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl_i (lvl),
         .rise_i(rise),
         .fall_i(fall),
         .src_i (cfg_src_i[k*SEL_W +: SEL_W]),
         .cond_i(cfg_cond_i[k*PM_COND_W +: PM_COND_W]),
         .run_i (pm_mode_i),
         .clr_i (detect_clr_i),
         .cond_o(cond_vec[k])
      );
   end

   pm_chain #(.NUM_SLICE(NUM_SLICE)) u_chain (
      .cond_i    (cond_vec),
      .endp_i    (cfg_endp_i),
      .eff_endp_o(eff_endp),
      .term_o    (term_vec)
   );

   assign status_d = pm_mode_i ? term_vec : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         clr_q    <= '0;
         event_q  <= 1'b0;
      end else begin
         status_q <= status_d;
         event_q  <= evt_en_i & (|status_d) & ~(|status_q);
         if (detect_clr_i) clr_q <= ~status_q;
      end
   end

   assign match_status_o = status_q;
   assign match_o        = |status_q;
   assign event_o        = event_q;
   assign clr_status_o   = clr_q;

   // R7: the event pulse lasts a single cycle
   assert_event_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |=> !event_o);

   // R7: an event needs the enable at the edge that raised the match
   assert_event_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> ($past(evt_en_i) && match_o));

   // R6: only endpoint slices carry a status bit
   assert_status_endpoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) || ((match_status_o & ~$past(eff_endp)) == '0));

   // R8: idle mode forces the outputs low
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_mode_i |=> (match_status_o == '0 && !event_o));

   // R9: the captured vector is the inverse of the previous status
   assert_clr_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      detect_clr_i |=> (clr_status_o == ~$past(match_status_o)));

endmodule

// File: tb/pattern_match_engine_bench.sv
`timescale 1ns/1ps
module pattern_match_engine_bench;

   localparam int NI = 8;
   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] pins = '0;
   logic [NS*3-1:0] src_v = '0;
   logic [NS*3-1:0] cond_v = '0;
   logic [NS-1:0] endp_v = '0;
   logic          mode = 1'b0;
   logic          evt_en = 1'b0;
   logic          dclr = 1'b0;

   logic [NS-1:0] status, clr_st;
   logic          match, evnt;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pattern_match_engine u_pattern_match_engine (
      .clk(clk), .rst_n(rst_n), .pins_i(pins),
      .cfg_src_i(src_v), .cfg_cond_i(cond_v), .cfg_endp_i(endp_v),
      .pm_mode_i(mode), .evt_en_i(evt_en), .detect_clr_i(dclr),
      .match_status_o(status), .match_o(match), .event_o(evnt),
      .clr_status_o(clr_st)
   );

   // Behavioural reference model
   bit [NI-1:0] m_s1, m_s2, m_prev;
   bit [NS-1:0] m_stk, m_status, m_clr;
   bit          m_event;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
         m_stk <= '0; m_status <= '0; m_clr <= '0; m_event <= 0;
      end else begin
         bit [NS-1:0] ct, hit, term;
         bit acc;
         for (int k = 0; k < NS; k++) begin
            int s, c;
            bit lv, r, f;
            s = int'(src_v[k*3 +: 3]);
            c = int'(cond_v[k*3 +: 3]);
            lv = m_s2[s];
            r = m_s2[s] && !m_prev[s];
            f = !m_s2[s] && m_prev[s];
            hit[k] = (c == 1 && r) || (c == 2 && f) || (c == 3 && (r || f));
            case (c)
               0: ct[k] = 1;
               1, 2, 3: ct[k] = m_stk[k] || hit[k];
               4: ct[k] = lv;
               5: ct[k] = !lv;
               6: ct[k] = 0;
               default: ct[k] = r || f;
            endcase
         end
         acc = 1;
         term = '0;
         for (int k = 0; k < NS; k++) begin
            acc = acc && ct[k];
            if (endp_v[k] || k == NS-1) begin
               term[k] = acc;
               acc = 1;
            end
         end
         if (!mode) term = '0;
         m_event  <= evt_en && (term != 0) && (m_status == 0);
         m_status <= term;
         if (dclr) m_clr <= ~m_status;
         m_stk <= (!mode || dclr) ? '0 : (m_stk | hit);
         m_prev <= m_s2;
         m_s2 <= m_s1;
         m_s1 <= pins;
      end
   end

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R6 status vs model", 64'(status), 64'(m_status));
         check("R7 match vs model", 64'(match), 64'(|m_status));
         check("R7 event vs model", 64'(evnt), 64'(m_event));
         check("R9 clr_status vs model", 64'(clr_st), 64'(m_clr));
      end
   end

   int ev_cnt = 0;
   int s0_cnt = 0;
   always @(negedge clk) begin
      if (evnt) ev_cnt++;
      if (status[0]) s0_cnt++;
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_slice(int k, int s, int c, bit e);
      src_v[k*3 +: 3]  = 3'(s);
      cond_v[k*3 +: 3] = 3'(c);
      endp_v[k]        = e;
   endtask

   task automatic blank_cfg();
      for (int k = 0; k < NS; k++) set_slice(k, 0, 6, 0);
   endtask

   task automatic pulse_clr();
      dclr = 1;
      @(negedge clk);
      dclr = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      blank_cfg();
      idle(3);
      // R10: reset state
      check("R10 status after reset", 64'(status), 0);
      check("R10 match after reset", 64'(match), 0);
      check("R10 event after reset", 64'(evnt), 0);
      check("R10 clr_status after reset", 64'(clr_st), 0);
      rst_n = 1;
      mode = 1;
      idle(2);

      // R1 R2 R5: term = in2 high AND in5 low, closing at slice 1
      set_slice(0, 2, 4, 0);
      set_slice(1, 5, 5, 1);
      pins = 8'b0000_0100;
      idle(5);
      check("R5 two-slice term matches", 64'(status), 64'h02);
      check("R1 match high", 64'(match), 1);
      pins = 8'b0010_0100;
      idle(5);
      check("R2 low-level condition fails", 64'(status), 64'h00);

      // R6: latency of two synchroniser stages plus status register
      pins = 8'b0000_0100;
      @(negedge clk);
      check("R6 latency edge+1", 64'(status), 0);
      @(negedge clk);
      check("R6 latency edge+2", 64'(status), 0);
      @(negedge clk);
      check("R6 latency edge+3", 64'(status), 64'h02);

      // R2: a never condition inside a term blocks it
      set_slice(1, 5, 6, 1);
      idle(2);
      check("R2 never condition blocks term", 64'(status), 0);

      // R5: last slice is an endpoint even with no flags
      for (int k = 0; k < NS; k++) set_slice(k, 0, 0, 0);
      idle(2);
      check("R5 last slice forced endpoint", 64'(status), 64'h80);

      // R3: remembered rise on in0 survives the line returning low
      blank_cfg();
      pins = '0;
      idle(4);
      set_slice(0, 0, 1, 1);
      pins[0] = 1;
      idle(2);
      pins[0] = 0;
      idle(6);
      check("R3 sticky rise held", 64'(status), 64'h01);
      pulse_clr();
      check("R9 captured not-matched vector", 64'(clr_st), 64'hFE);
      idle(3);
      check("R3 sticky cleared by command", 64'(status), 0);
      check("R9 captured vector held", 64'(clr_st), 64'hFE);

      // R4: non-remembered edge lasts one cycle
      blank_cfg();
      set_slice(0, 1, 7, 1);
      idle(3);
      s0_cnt = 0;
      pins[1] = 1;
      idle(6);
      check("R4 single-cycle edge term", 64'(s0_cnt), 1);

      // R7: one event per rise when enabled, none when disabled
      blank_cfg();
      set_slice(0, 2, 4, 1);
      pins[2] = 0;
      evt_en = 1;
      idle(5);
      ev_cnt = 0;
      pins[2] = 1;
      idle(8);
      check("R7 one event per rise", 64'(ev_cnt), 1);
      evt_en = 0;
      pins[2] = 0;
      idle(5);
      ev_cnt = 0;
      pins[2] = 1;
      idle(8);
      check("R7 no event while disabled", 64'(ev_cnt), 0);
      check("R7 match still reported", 64'(match), 1);

      // R8: idle mode forces outputs low and forgets edges
      mode = 0;
      idle(3);
      check("R8 status idle", 64'(status), 0);
      check("R8 match idle", 64'(match), 0);
      blank_cfg();
      set_slice(0, 3, 2, 1);
      mode = 1;
      pins[3] = 1;
      idle(4);
      pins[3] = 0;
      idle(5);
      check("R3 sticky fall held", 64'(status), 64'h01);
      mode = 0;
      idle(2);
      mode = 1;
      idle(3);
      check("R8 idle mode cleared sticky", 64'(status), 0);

      idle(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule